// File: doc/BRIEF.md
# Multithreaded Register Rename Map

This block is the rename stage of a simultaneous multithreaded out-of-order core. Every hardware thread has its own table that translates architectural register numbers into physical register numbers. All threads draw destination registers from one physical register pool, which a single first-in first-out free list manages.

In each cycle, every thread may offer one instruction. A round-robin selector grants one of the requesting threads. The granted instruction gets its two source operands translated through that thread's table. If it writes a real destination, it takes the register at the head of the free list and records it as the new mapping. The mapping it replaces is returned so that the retire logic can give it back later. A separate commit input pushes a released physical register onto the tail of the free list.

The pool holds threads × architectural registers + in-flight instructions entries. At reset, thread t's register r maps to physical t·NUM_ARCH + r. The free list starts with the remaining registers in ascending order.

Top module: `smt_rename_map`

## Requirements
- R1: After reset, a source lookup of architectural register r by thread t returns physical register t·NUM_ARCH + r.
- R2: After reset, the free list holds NUM_THREADS·NUM_ARCH up to NUM_PHYS−1 in ascending order, and allocations consume them in that order.
- R3: The grant goes to the first requesting thread after the last granted thread, in increasing thread index with wrap-around. The pointer starts so that thread 0 is first. Threads without a request are skipped.
- R4: At most one thread is granted per cycle, and only one that is requesting. ren_valid_o is high exactly when a grant occurs, and ren_tid_o gives the granted thread.
- R5: A granted instruction with req_has_dst_i set and a nonzero destination allocates the free-list head. It drives that register on ren_dst_phys_o, raises ren_alloc_o, and updates its thread's mapping so that later lookups of that register return it.
- R6: ren_old_phys_o carries the mapping of the destination register as it stood before the rename.
- R7: A granted instruction whose destination is register 0, or whose req_has_dst_i is low, allocates nothing. ren_alloc_o is low, ren_dst_phys_o equals the current mapping, and both the map and the free list are unchanged.
- R8: When the free list is empty, no thread is granted, and stall_o is high if any thread requests.
- R9: A commit push and an allocation pop in the same cycle both take effect. Pushed registers are handed out again in first-in first-out order, including a push made while the list was empty.
- R10: Lookups use only the granted thread's table, so the same architectural register number in two threads maps independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_THREADS | Per-thread rename request |
| req_src_a_i | input | NUM_THREADS·AW | Per-thread first source register, thread t at bits [t·AW +: AW] |
| req_src_b_i | input | NUM_THREADS·AW | Per-thread second source register, same packing |
| req_dst_i | input | NUM_THREADS·AW | Per-thread destination register, same packing |
| req_has_dst_i | input | NUM_THREADS | Per-thread flag: instruction writes a destination |
| free_valid_i | input | 1 | Commit returns a physical register this cycle |
| free_phys_i | input | PW | Physical register being returned |
| ren_valid_o | output | 1 | A rename is granted this cycle |
| ren_tid_o | output | TW | Granted thread |
| ren_src_a_phys_o | output | PW | Physical register for the first source |
| ren_src_b_phys_o | output | PW | Physical register for the second source |
| ren_dst_phys_o | output | PW | New destination register, or the current mapping when nothing is allocated |
| ren_old_phys_o | output | PW | Previous mapping of the destination |
| ren_alloc_o | output | 1 | A physical register was taken from the free list |
| stall_o | output | 1 | Requests are blocked because the free list is empty |

## Verification
The bench drives four patterns:
- Both threads requesting together. This separates true alternation from a fixed priority.
- A single thread requesting back to back. This shows that idle threads are skipped rather than waited on.
- Destination cases with a real register, register 0, and no destination. These show whether allocation, the map update and the free list move only when they should.
- A long run of allocations that drains the pool, followed by commits while empty and while popping. This distinguishes a correct empty stall and simultaneous push/pop from an off-by-one count or a lost push.

Cross-thread lookups of the same register number expose any aliasing between the per-thread tables.

// File: rtl/rename_pkg.sv
package rename_pkg;
  function automatic int phys_count(int threads, int arch, int inflight);
    return threads * arch + inflight;
  endfunction

  function automatic int safe_clog2(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/smt_rr_arbiter.sv
module smt_rr_arbiter #(
  parameter int NUM_THREADS = 2,
  localparam int TW = rename_pkg::safe_clog2(NUM_THREADS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_THREADS-1:0] req_i,
  output logic [NUM_THREADS-1:0] grant_o,
  output logic                   valid_o,
  output logic [TW-1:0]          tid_o
);
  logic [TW-1:0] last_q;

  always_comb begin
    grant_o = '0;
    valid_o = 1'b0;
    tid_o   = '0;
    for (int k = 1; k <= NUM_THREADS; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NUM_THREADS;
      if (!valid_o && req_i[idx]) begin
        valid_o      = 1'b1;
        tid_o        = TW'(idx);
        grant_o[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_q <= TW'(NUM_THREADS - 1);
    else if (valid_o) last_q <= tid_o;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o) && (valid_o == (grant_o != '0))); // R4
  AST_GRANT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o & ~req_i) == '0); // R4
  AST_PTR_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> (last_q == $past(tid_o))); // R3
endmodule

// File: rtl/smt_free_list.sv
module smt_free_list #(
  parameter int NUM_PHYS  = 24,
  parameter int INIT_BASE = 16,
  localparam int PW = rename_pkg::safe_clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic          push_i,
  input  logic [PW-1:0] push_phys_i,
  output logic [PW-1:0] head_phys_o,
  output logic          empty_o
);
  localparam int INIT_CNT = NUM_PHYS - INIT_BASE;

  logic [PW-1:0] mem_q [NUM_PHYS];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  function automatic logic [PW-1:0] wrap_inc(logic [PW-1:0] p);
    return (int'(p) == NUM_PHYS - 1) ? '0 : p + 1'b1;
  endfunction

  assign head_phys_o = mem_q[head_q];
  assign empty_o     = (count_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PHYS; i++)
        mem_q[i] <= (i < INIT_CNT) ? PW'(INIT_BASE + i) : '0;
      head_q  <= '0;
      tail_q  <= PW'(INIT_CNT % NUM_PHYS);
      count_q <= CW'(INIT_CNT);
    end else begin
      if (push_i) begin
        mem_q[tail_q] <= push_phys_i;
        tail_q        <= wrap_inc(tail_q);
      end
      if (pop_i) head_q <= wrap_inc(head_q);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_q) <= NUM_PHYS); // R9
  AST_PUSH_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (int'(count_q) < NUM_PHYS)); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R8
endmodule

// File: rtl/smt_map_table.sv
module smt_map_table #(
  parameter int NUM_THREADS = 2,
  parameter int NUM_ARCH    = 8,
  parameter int NUM_PHYS    = 24,
  localparam int TW = rename_pkg::safe_clog2(NUM_THREADS),
  localparam int AW = rename_pkg::safe_clog2(NUM_ARCH),
  localparam int PW = rename_pkg::safe_clog2(NUM_PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] tid_i,
  input  logic [AW-1:0] src_a_i,
  input  logic [AW-1:0] src_b_i,
  input  logic [AW-1:0] dst_i,
  input  logic          we_i,
  input  logic [PW-1:0] new_phys_i,
  output logic [PW-1:0] src_a_phys_o,
  output logic [PW-1:0] src_b_phys_o,
  output logic [PW-1:0] dst_phys_o
);
  logic [PW-1:0] map_q [NUM_THREADS][NUM_ARCH];

  assign src_a_phys_o = map_q[tid_i][src_a_i];
  assign src_b_phys_o = map_q[tid_i][src_b_i];
  assign dst_phys_o   = map_q[tid_i][dst_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int t = 0; t < NUM_THREADS; t++)
        for (int r = 0; r < NUM_ARCH; r++)
          map_q[t][r] <= PW'(t * NUM_ARCH + r);
    end else if (we_i) begin
      map_q[tid_i][dst_i] <= new_phys_i;
    end
  end

  AST_MAP_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (map_q[$past(tid_i)][$past(dst_i)] == $past(new_phys_i))); // R5
endmodule

// File: rtl/smt_rename_map.sv
module smt_rename_map #(
  parameter int NUM_THREADS = 2,
  parameter int NUM_ARCH    = 8,
  parameter int IN_FLIGHT   = 8,
  localparam int NUM_PHYS = rename_pkg::phys_count(NUM_THREADS, NUM_ARCH, IN_FLIGHT),
  localparam int TW = rename_pkg::safe_clog2(NUM_THREADS),
  localparam int AW = rename_pkg::safe_clog2(NUM_ARCH),
  localparam int PW = rename_pkg::safe_clog2(NUM_PHYS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_THREADS-1:0]    req_valid_i,
  input  logic [NUM_THREADS*AW-1:0] req_src_a_i,
  input  logic [NUM_THREADS*AW-1:0] req_src_b_i,
  input  logic [NUM_THREADS*AW-1:0] req_dst_i,
  input  logic [NUM_THREADS-1:0]    req_has_dst_i,
  input  logic                      free_valid_i,
  input  logic [PW-1:0]             free_phys_i,
  output logic                      ren_valid_o,
  output logic [TW-1:0]             ren_tid_o,
  output logic [PW-1:0]             ren_src_a_phys_o,
  output logic [PW-1:0]             ren_src_b_phys_o,
  output logic [PW-1:0]             ren_dst_phys_o,
  output logic [PW-1:0]             ren_old_phys_o,
  output logic                      ren_alloc_o,
  output logic                      stall_o
);
  logic                   fl_empty;
  logic [PW-1:0]          fl_head;
  logic [NUM_THREADS-1:0] arb_req, grant;
  logic [AW-1:0]          sel_src_a, sel_src_b, sel_dst;
  logic                   sel_has_dst;

  // requests are masked when nothing can be allocated
  assign arb_req = req_valid_i & {NUM_THREADS{~fl_empty}};
  assign stall_o = (|req_valid_i) & fl_empty;

  smt_rr_arbiter #(.NUM_THREADS(NUM_THREADS)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (arb_req),
    .grant_o (grant),
    .valid_o (ren_valid_o),
    .tid_o   (ren_tid_o)
  );

  always_comb begin
    sel_src_a   = '0;
    sel_src_b   = '0;
    sel_dst     = '0;
    sel_has_dst = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (grant[t]) begin
        sel_src_a   = req_src_a_i[t*AW +: AW];
        sel_src_b   = req_src_b_i[t*AW +: AW];
        sel_dst     = req_dst_i[t*AW +: AW];
        sel_has_dst = req_has_dst_i[t];
      end
    end
  end

  assign ren_alloc_o    = ren_valid_o && sel_has_dst && (sel_dst != '0);
  assign ren_dst_phys_o = ren_alloc_o ? fl_head : ren_old_phys_o;

  smt_map_table #(
    .NUM_THREADS (NUM_THREADS),
    .NUM_ARCH    (NUM_ARCH),
    .NUM_PHYS    (NUM_PHYS)
  ) u_map (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tid_i        (ren_tid_o),
    .src_a_i      (sel_src_a),
    .src_b_i      (sel_src_b),
    .dst_i        (sel_dst),
    .we_i         (ren_alloc_o),
    .new_phys_i   (fl_head),
    .src_a_phys_o (ren_src_a_phys_o),
    .src_b_phys_o (ren_src_b_phys_o),
    .dst_phys_o   (ren_old_phys_o)
  );

  smt_free_list #(
    .NUM_PHYS  (NUM_PHYS),
    .INIT_BASE (NUM_THREADS * NUM_ARCH)
  ) u_fl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_i       (ren_alloc_o),
    .push_i      (free_valid_i),
    .push_phys_i (free_phys_i),
    .head_phys_o (fl_head),
    .empty_o     (fl_empty)
  );

  AST_STALL_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !ren_valid_o); // R8
  AST_ZERO_NO_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_o && (sel_dst == '0)) |-> !ren_alloc_o); // R7
  AST_ALLOC_IS_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ren_alloc_o |-> ren_valid_o); // R5
endmodule

// File: tb/smt_rename_map_bench.sv
module smt_rename_map_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T  = 2;
  localparam int A  = 8;
  localparam int F  = 8;
  localparam int P  = T * A + F;
  localparam int AW = 3;
  localparam int PW = 5;
  localparam int TW = 1;

  logic clk = 0, rst_n = 0;
  logic [T-1:0]    req_valid = '0, has_dst = '0;
  logic [T*AW-1:0] src_a = '0, src_b = '0, dst = '0;
  logic            free_valid = 0;
  logic [PW-1:0]   free_phys = '0;
  logic            ren_valid, ren_alloc, stall;
  logic [TW-1:0]   ren_tid;
  logic [PW-1:0]   sa_phys, sb_phys, d_phys, old_phys;

  always #(CLK_PERIOD/2) clk = ~clk;

  smt_rename_map u_smt_rename_map (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_src_a_i(src_a), .req_src_b_i(src_b),
    .req_dst_i(dst), .req_has_dst_i(has_dst),
    .free_valid_i(free_valid), .free_phys_i(free_phys),
    .ren_valid_o(ren_valid), .ren_tid_o(ren_tid),
    .ren_src_a_phys_o(sa_phys), .ren_src_b_phys_o(sb_phys),
    .ren_dst_phys_o(d_phys), .ren_old_phys_o(old_phys),
    .ren_alloc_o(ren_alloc), .stall_o(stall)
  );

  typedef struct {
    string tag;
    bit    valid, alloc, stall;
    int    tid, sa, sb, d, old;
  } exp_t;

  exp_t exp_q[$];
  int   compared = 0, mismatched = 0;
  bit   done = 0;

  int m_map [T][A];
  int m_fl[$];
  int m_last = T - 1;

  task automatic chk(string tag, string what, int act, int expv);
    compared++;
    if (act != expv) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.tag, "ren_valid", int'(ren_valid), int'(e.valid));
      chk(e.tag, "stall",     int'(stall),     int'(e.stall));
      if (e.valid) begin
        chk(e.tag, "tid",   int'(ren_tid),   e.tid);
        chk(e.tag, "src_a", int'(sa_phys),   e.sa);
        chk(e.tag, "src_b", int'(sb_phys),   e.sb);
        chk(e.tag, "old",   int'(old_phys),  e.old);
        chk(e.tag, "dst",   int'(d_phys),    e.d);
        chk(e.tag, "alloc", int'(ren_alloc), int'(e.alloc));
      end
    end
  end

  function automatic logic [T*AW-1:0] pk(int t0, int t1);
    return {AW'(t1), AW'(t0)};
  endfunction

  // driver: drives one cycle and pushes the expected result
  task automatic drive(string tag, logic [T-1:0] v, logic [T*AW-1:0] a,
                       logic [T*AW-1:0] b, logic [T*AW-1:0] d,
                       logic [T-1:0] hd, logic fv, int fp);
    exp_t e;
    int g;
    @(posedge clk); #1;
    req_valid = v; src_a = a; src_b = b; dst = d; has_dst = hd;
    free_valid = fv; free_phys = PW'(fp);
    e.tag = tag; e.valid = 0; e.alloc = 0; e.stall = 0;
    e.tid = 0; e.sa = 0; e.sb = 0; e.d = 0; e.old = 0;
    g = -1;
    if (m_fl.size() == 0) e.stall = (v != '0);
    else
      for (int k = 1; k <= T; k++) begin
        int i;
        i = (m_last + k) % T;
        if (g < 0 && v[i]) g = i;
      end
    if (g >= 0) begin
      int ra, rb, rd;
      ra = int'(a[g*AW +: AW]); rb = int'(b[g*AW +: AW]); rd = int'(d[g*AW +: AW]);
      e.valid = 1; e.tid = g;
      e.sa = m_map[g][ra]; e.sb = m_map[g][rb]; e.old = m_map[g][rd];
      e.alloc = hd[g] && rd != 0;
      e.d = e.alloc ? m_fl[0] : e.old;
      if (e.alloc) begin
        m_map[g][rd] = m_fl[0];
        void'(m_fl.pop_front());
      end
      m_last = g;
    end
    if (fv) m_fl.push_back(fp);
    exp_q.push_back(e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < T; t++)
      for (int r = 0; r < A; r++) m_map[t][r] = t * A + r;
    for (int i = T * A; i < P; i++) m_fl.push_back(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R4 reset", "ren_valid", int'(ren_valid), 0);
    chk("R8 reset", "stall", int'(stall), 0);

    // R1, R3: both threads request, no destinations, alternate grants
    drive("R1", 2'b11, pk(3, 3), pk(7, 0), pk(0, 0), 2'b00, 0, 0);
    drive("R1 R3", 2'b11, pk(3, 3), pk(7, 0), pk(0, 0), 2'b00, 0, 0);
    drive("R3", 2'b11, pk(1, 2), pk(4, 5), pk(0, 0), 2'b00, 0, 0);
    // R2, R5, R6: thread 1 then thread 0 write register 5
    drive("R2 R5 R6", 2'b11, pk(5, 5), pk(5, 5), pk(5, 5), 2'b11, 0, 0);
    drive("R2 R5 R6", 2'b11, pk(5, 5), pk(5, 5), pk(5, 5), 2'b11, 0, 0);
    // R10: same register number seen through each table
    drive("R10", 2'b01, pk(5, 0), pk(2, 0), pk(0, 0), 2'b00, 0, 0);
    drive("R10", 2'b10, pk(0, 5), pk(0, 2), pk(0, 0), 2'b00, 0, 0);
    // R7: destination zero and no-destination cases, then the next allocation
    drive("R7 dst0", 2'b01, pk(5, 0), pk(0, 0), pk(0, 0), 2'b01, 0, 0);
    drive("R7 nodst", 2'b01, pk(5, 0), pk(6, 0), pk(6, 0), 2'b00, 0, 0);
    drive("R7 after", 2'b01, pk(6, 0), pk(6, 0), pk(6, 0), 2'b01, 0, 0);
    // R3: lone thread granted back to back
    drive("R3 lone", 2'b10, pk(0, 1), pk(0, 2), pk(0, 3), 2'b10, 0, 0);
    drive("R3 lone", 2'b10, pk(0, 3), pk(0, 3), pk(0, 3), 2'b10, 0, 0);
    // R8: drain the pool
    while (m_fl.size() > 0)
      drive("R8 drain", 2'b01, pk(1, 0), pk(2, 0), pk(1, 0), 2'b01, 0, 0);
    drive("R8 empty", 2'b11, pk(1, 1), pk(2, 2), pk(1, 1), 2'b11, 0, 0);
    // R9: push while empty, then push and pop together
    drive("R9 push empty", 2'b01, pk(1, 0), pk(0, 0), pk(2, 0), 2'b01, 1, 5);
    drive("R9 reuse", 2'b01, pk(2, 0), pk(0, 0), pk(2, 0), 2'b01, 1, 13);
    drive("R9 push+pop", 2'b01, pk(2, 0), pk(0, 0), pk(3, 0), 2'b01, 1, 21);
    drive("R9 fifo", 2'b10, pk(0, 3), pk(0, 0), pk(0, 4), 2'b10, 0, 0);
    drive("R9 fifo", 2'b01, pk(3, 0), pk(2, 0), pk(4, 0), 2'b01, 0, 0);
    drive("R8 empty again", 2'b01, pk(4, 0), pk(0, 0), pk(4, 0), 2'b01, 0, 0);
    drive("R4 idle", 2'b00, pk(0, 0), pk(0, 0), pk(0, 0), 2'b00, 0, 0);
    @(posedge clk); #1;
    req_valid = '0; free_valid = 0;
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule